// File: doc/BRIEF.md
# Processor-to-Memory Crossbar Switch

This block connects NP processors to NM memory modules through a full crossbar. Each processor port carries a request, an address, a write enable and write data. The top bits of the address select a memory module, and the remaining bits form the local word address within that module. Every memory module has its own crosspoint. A crosspoint combines a fixed-priority encoder and a multiplexer. It picks one of the processors currently addressing that module and steers that processor's address, write enable and write data onto the module port. One cycle later it returns an acknowledge pulse to the chosen processor.

The crosspoints work independently of each other. Processors that address different modules are all served in the same cycle. Processors that address the same module are served one per cycle in index order. A processor holds its request until it sees its acknowledge, and it has at most one request open at a time. The memory modules sit outside the block. Each one is a synchronous memory that registers read data one cycle after it is enabled. That read data reaches the acknowledged processor on its read-data lane in the same cycle as the acknowledge.

Each crosspoint runs a two-state machine:
- XP_IDLE means no grant is outstanding.
- XP_SERVE means a grant issued on the previous edge is being acknowledged.

The machine has four transitions:
- ACCEPT: XP_IDLE to XP_SERVE, when some eligible processor addresses the module.
- CHAIN: XP_SERVE to XP_SERVE, when another eligible processor is waiting.
- RELEASE: XP_SERVE to XP_IDLE, when no eligible processor is waiting.
- WAIT: XP_IDLE to XP_IDLE, when no eligible processor is waiting.

Each grant also stores the winning processor index as the owner.

Top module: `xbar_switch`

## Requirements
- R1: While reset is asserted, and after it is released with no requests pending, every p_ack bit is 0 and every m_en bit is 0.
- R2: A processor address is split as {module index, local address}. The module index is the top log2(NM) bits, and the local address is the low AW-log2(NM) bits. The local address appears unchanged on the m_addr lane of the selected module in the same cycle as the request.
- R3: When several eligible processors address one module in the same cycle, the lowest-numbered one is granted. An eligible processor 0 is therefore always acknowledged in the next cycle.
- R4: p_ack[p] is a one-cycle pulse. It rises in the cycle after the cycle in which processor p was granted, and only for a processor that was requesting in the grant cycle.
- R5: A processor that loses arbitration and keeps its request asserted is acknowledged later. Every request is acknowledged exactly once.
- R6: Processors addressing different modules are granted in the same cycle. Each cycle, the number of p_ack bits set equals the number of m_en bits set in the previous cycle.
- R7: For a read, p_rdata of the acknowledged processor carries the module's read data in the ACK cycle. For a write, that lane carries whatever the module returns. A processor whose p_ack is 0 sees 0 on its p_rdata lane.
- R8: During a grant, m_en of the module is 1, and m_we and m_wdata equal the winning processor's write enable and write data.
- R9: A processor's request is not considered in any cycle where its p_ack is 1. A request presented or held in that cycle is granted no earlier than the next cycle, so no operation is acknowledged twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| p_req | input | NP | Per-processor request, held until acknowledged |
| p_we | input | NP | Per-processor write enable (1 = write) |
| p_addr | input | NP*AW | Per-processor address, lane p at [p*AW +: AW] |
| p_wdata | input | NP*DW | Per-processor write data, lane p at [p*DW +: DW] |
| p_ack | output | NP | Per-processor one-cycle acknowledge |
| p_rdata | output | NP*DW | Per-processor read data, valid with p_ack |
| m_en | output | NM | Per-module access enable |
| m_we | output | NM | Per-module write enable |
| m_addr | output | NM*(AW-log2(NM)) | Per-module local word address |
| m_wdata | output | NM*DW | Per-module write data |
| m_rdata | input | NM*DW | Per-module read data, registered by the module |

## Verification
The module-side outputs (m_en, m_we, m_addr, m_wdata) respond combinationally in the cycle a request is presented. The bench checks them one time unit after driving a request at the falling edge.

The acknowledge and read data are due one cycle after the grant. When k higher-priority processors compete for the same module, they are due k further cycles later. A request presented while the processor's own acknowledge is high slips one extra cycle.

The driver stamps each expected acknowledge with its absolute cycle number when it issues the request. At each falling edge, the monitor matches every p_ack bit against that stamp. An acknowledge that comes early, comes late, repeats or never arrives counts as a miscompare.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    // Crosspoint control states
    typedef enum logic {
        XP_IDLE  = 1'b0,
        XP_SERVE = 1'b1
    } xp_state_t;

    // Width of an index that selects one of n items (at least one bit)
    function automatic int sel_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/xbar_decode.sv
// Address decode: marks, per module, which processors are eligible this cycle.
// A processor whose acknowledge is high in this cycle is held off.
module xbar_decode #(
    parameter int NP = 4,
    parameter int NM = 4,
    parameter int AW = 8
) (
    input  logic [NP-1:0]    req_i,
    input  logic [NP*AW-1:0] addr_i,
    input  logic [NP-1:0]    busy_i,
    output logic [NM*NP-1:0] want_o
);
    localparam int MSW = xbar_pkg::sel_bits(NM);

    for (genvar p = 0; p < NP; p++) begin : g_proc
        logic [MSW-1:0] module_idx;
        assign module_idx = addr_i[p*AW+AW-1 -: MSW];
        for (genvar m = 0; m < NM; m++) begin : g_mod
            assign want_o[m*NP+p] = req_i[p] & ~busy_i[p] & (module_idx == MSW'(m));
        end
    end

endmodule

// File: rtl/xbar_xpoint.sv
// One crosspoint column: fixed-priority encoder, steering multiplexer and
// grant/acknowledge state machine for a single memory module.
module xbar_xpoint
    import xbar_pkg::*;
#(
    parameter int NP  = 4,
    parameter int AW  = 8,
    parameter int LAW = 6,
    parameter int DW  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NP-1:0]    want_i,
    input  logic [NP*AW-1:0] addr_i,
    input  logic [NP-1:0]    we_i,
    input  logic [NP*DW-1:0] wdata_i,
    output logic             m_en_o,
    output logic             m_we_o,
    output logic [LAW-1:0]   m_addr_o,
    output logic [DW-1:0]    m_wdata_o,
    output logic [NP-1:0]    ack_o
);
    localparam int PW = sel_bits(NP);

    logic          hit;
    logic [PW-1:0] sel;
    xp_state_t     state_q, state_d;
    logic [PW-1:0] owner_q, owner_d;

    // Priority encoder: lowest index wins
    always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int i = NP - 1; i >= 0; i--) begin
            if (want_i[i]) begin
                hit = 1'b1;
                sel = PW'(i);
            end
        end
    end

    // Steering multiplexer toward the module port
    always_comb begin
        m_en_o    = hit;
        m_we_o    = hit & we_i[sel];
        m_addr_o  = addr_i[sel*AW +: LAW];
        m_wdata_o = wdata_i[sel*DW +: DW];
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        unique case (state_q)
            XP_IDLE: begin
                if (hit) begin
                    state_d = XP_SERVE;   // ACCEPT
                    owner_d = sel;
                end
            end
            XP_SERVE: begin
                if (hit) begin
                    state_d = XP_SERVE;   // CHAIN
                    owner_d = sel;
                end else begin
                    state_d = XP_IDLE;    // RELEASE
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= XP_IDLE;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
        end
    end

    // Outputs from state: acknowledge the owner while serving
    always_comb begin
        ack_o = '0;
        unique case (state_q)
            XP_IDLE:  ack_o = '0;
            XP_SERVE: ack_o[owner_q] = 1'b1;
        endcase
    end

endmodule

// File: rtl/xbar_return.sv
// Return path: folds the per-module acknowledges into per-processor
// acknowledge and read-data lanes.
module xbar_return #(
    parameter int NP = 4,
    parameter int NM = 4,
    parameter int DW = 16
) (
    input  logic [NM*NP-1:0] ack_all_i,
    input  logic [NM*DW-1:0] m_rdata_i,
    output logic [NP-1:0]    p_ack_o,
    output logic [NP*DW-1:0] p_rdata_o
);
    always_comb begin
        p_ack_o   = '0;
        p_rdata_o = '0;
        for (int p = 0; p < NP; p++) begin
            for (int m = 0; m < NM; m++) begin
                if (ack_all_i[m*NP+p]) begin
                    p_ack_o[p] = 1'b1;
                    p_rdata_o[p*DW +: DW] = p_rdata_o[p*DW +: DW] | m_rdata_i[m*DW +: DW];
                end
            end
        end
    end

endmodule

// File: rtl/xbar_switch.sv
// NP x NM crossbar with an independent priority crosspoint per memory module.
// NM must be a power of two and at least 2.
module xbar_switch #(
    parameter int NP = 4,
    parameter int NM = 4,
    parameter int AW = 8,
    parameter int DW = 16,
    localparam int LAW = AW - xbar_pkg::sel_bits(NM)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NP-1:0]     p_req,
    input  logic [NP-1:0]     p_we,
    input  logic [NP*AW-1:0]  p_addr,
    input  logic [NP*DW-1:0]  p_wdata,
    output logic [NP-1:0]     p_ack,
    output logic [NP*DW-1:0]  p_rdata,
    output logic [NM-1:0]     m_en,
    output logic [NM-1:0]     m_we,
    output logic [NM*LAW-1:0] m_addr,
    output logic [NM*DW-1:0]  m_wdata,
    input  logic [NM*DW-1:0]  m_rdata
);
    logic [NM*NP-1:0] want_all;
    logic [NM*NP-1:0] ack_all;

    xbar_decode #(.NP(NP), .NM(NM), .AW(AW)) u_decode (
        .req_i  (p_req),
        .addr_i (p_addr),
        .busy_i (p_ack),
        .want_o (want_all)
    );

    for (genvar m = 0; m < NM; m++) begin : g_xp
        xbar_xpoint #(.NP(NP), .AW(AW), .LAW(LAW), .DW(DW)) u_xp (
            .clk       (clk),
            .rst_n     (rst_n),
            .want_i    (want_all[m*NP +: NP]),
            .addr_i    (p_addr),
            .we_i      (p_we),
            .wdata_i   (p_wdata),
            .m_en_o    (m_en[m]),
            .m_we_o    (m_we[m]),
            .m_addr_o  (m_addr[m*LAW +: LAW]),
            .m_wdata_o (m_wdata[m*DW +: DW]),
            .ack_o     (ack_all[m*NP +: NP])
        );
    end

    xbar_return #(.NP(NP), .NM(NM), .DW(DW)) u_return (
        .ack_all_i (ack_all),
        .m_rdata_i (m_rdata),
        .p_ack_o   (p_ack),
        .p_rdata_o (p_rdata)
    );

endmodule

// File: rtl/xbar_switch_chk.sv
module xbar_switch_chk #(
    parameter int NP = 4,
    parameter int NM = 4,
    parameter int DW = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NP-1:0]    p_req,
    input logic [NP-1:0]    p_ack,
    input logic [NP*DW-1:0] p_rdata,
    input logic [NM-1:0]    m_en
);
    // R1: reset leaves all acknowledges low
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (p_ack == '0));

    // R4, R9: acknowledge never lasts two cycles
    p_ack_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((p_ack & $past(p_ack)) == '0));

    // R4: acknowledge only follows a request
    p_ack_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((p_ack & ~$past(p_req)) == '0));

    // R3: an eligible processor 0 always wins
    p_top_priority_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (p_req[0] && !p_ack[0]) |=> p_ack[0]);

    // R6: one acknowledge per enabled module, concurrently
    p_grant_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(p_ack) == $countones($past(m_en))));

    // R7: idle lanes return zero
    for (genvar p = 0; p < NP; p++) begin : g_lane
        p_rdata_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !p_ack[p] |-> (p_rdata[p*DW +: DW] == '0));
    end

endmodule

bind xbar_switch xbar_switch_chk #(.NP(NP), .NM(NM), .DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .p_req   (p_req),
    .p_ack   (p_ack),
    .p_rdata (p_rdata),
    .m_en    (m_en)
);

// File: tb/xbar_switch_test.sv
module xbar_switch_test;
    localparam int NP    = 4;
    localparam int NM    = 4;
    localparam int AW    = 8;
    localparam int DW    = 16;
    localparam int MSW   = 2;
    localparam int LAW   = AW - MSW;
    localparam int DEPTH = 1 << LAW;

    typedef struct {
        int           p;
        int           cyc;
        logic [DW-1:0] rd;
        string        tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP-1:0]     p_req = '0;
    logic [NP-1:0]     p_we = '0;
    logic [NP*AW-1:0]  p_addr = '0;
    logic [NP*DW-1:0]  p_wdata = '0;
    logic [NP-1:0]     p_ack;
    logic [NP*DW-1:0]  p_rdata;
    logic [NM-1:0]     m_en;
    logic [NM-1:0]     m_we;
    logic [NM*LAW-1:0] m_addr;
    logic [NM*DW-1:0]  m_wdata;
    logic [NM*DW-1:0]  m_rdata;

    int   vectors = 0;
    int   fails = 0;
    int   cyc = 0;
    bit   done = 1'b0;
    exp_t sb[$];
    logic [DW-1:0] mem [NM][DEPTH];
    logic [DW-1:0] sh  [NM][DEPTH];

    xbar_switch #(.NP(NP), .NM(NM), .AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .p_req(p_req), .p_we(p_we), .p_addr(p_addr),
        .p_wdata(p_wdata), .p_ack(p_ack), .p_rdata(p_rdata), .m_en(m_en),
        .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Synchronous single-cycle memory modules
    always @(posedge clk) begin
        for (int m = 0; m < NM; m++) begin
            if (m_en[m]) begin
                if (m_we[m]) begin
                    mem[m][m_addr[m*LAW +: LAW]] <= m_wdata[m*DW +: DW];
                    m_rdata[m*DW +: DW] <= '0;
                end else begin
                    m_rdata[m*DW +: DW] <= mem[m][m_addr[m*LAW +: LAW]];
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    // Driver: present a request and push its expected acknowledge
    task automatic issue(input int p, input bit we, input int m, input int la,
                         input logic [DW-1:0] wd, input int lat, input string tag);
        exp_t e;
        p_req[p] = 1'b1;
        p_we[p]  = we;
        p_addr[p*AW +: AW]  = AW'((m << LAW) | la);
        p_wdata[p*DW +: DW] = wd;
        e.p   = p;
        e.cyc = cyc + lat;
        e.tag = tag;
        if (we) begin
            e.rd = '0;
            sh[m][la] = wd;
        end else begin
            e.rd = sh[m][la];
        end
        sb.push_back(e);
    endtask

    // Advance one cycle; processors drop requests that were acknowledged
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        for (int p = 0; p < NP; p++)
            if (p_ack[p]) p_req[p] = 1'b0;
    endtask

    // Monitor: pops expected acknowledges at their due cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int p = 0; p < NP; p++) begin
                if (p_ack[p]) begin
                    int hit_i;
                    hit_i = -1;
                    for (int i = 0; i < sb.size(); i++)
                        if (sb[i].p == p && sb[i].cyc == cyc) hit_i = i;
                    vectors++;
                    if (hit_i < 0) begin
                        fails++;
                        $display("FAIL R4: unexpected ack proc %0d cycle %0d actual 1 expected 0", p, cyc);
                    end else begin
                        vectors++;
                        if (p_rdata[p*DW +: DW] !== sb[hit_i].rd) begin
                            fails++;
                            $display("FAIL %s: rdata proc %0d actual %0h expected %0h",
                                     sb[hit_i].tag, p, p_rdata[p*DW +: DW], sb[hit_i].rd);
                        end
                        sb.delete(hit_i);
                    end
                end else begin
                    vectors++;
                    if (p_rdata[p*DW +: DW] !== '0) begin
                        fails++;
                        $display("FAIL R7: idle lane %0d actual %0h expected 0", p, p_rdata[p*DW +: DW]);
                    end
                end
            end
            for (int i = sb.size() - 1; i >= 0; i--) begin
                if (sb[i].cyc < cyc) begin
                    vectors++;
                    fails++;
                    $display("FAIL %s: missing ack proc %0d due cycle %0d actual 0 expected 1",
                             sb[i].tag, sb[i].p, sb[i].cyc);
                    sb.delete(i);
                end
            end
        end
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(p_ack == '0, "R1", "ack in reset", 64'(p_ack), 0);
        chk(m_en == '0, "R1", "m_en in reset", 64'(m_en), 0);
        rst_n = 1'b1;
        step();
        chk(p_ack == '0, "R1", "ack after reset", 64'(p_ack), 0);

        // R6, R8: four writes to four modules in one cycle
        for (int p = 0; p < NP; p++)
            issue(p, 1'b1, p, 5, DW'(16'hA000 + p * 16'h0111), 1, "R6");
        #1;
        chk(m_en == 4'hF, "R6", "all modules enabled", 64'(m_en), 64'hF);
        chk(m_we == 4'hF, "R8", "all writes", 64'(m_we), 64'hF);
        chk(m_addr[2*LAW +: LAW] == 5, "R2", "local address lane 2", 64'(m_addr[2*LAW +: LAW]), 5);
        chk(m_wdata[2*DW +: DW] == 16'hA222, "R8", "wdata lane 2", 64'(m_wdata[2*DW +: DW]), 64'hA222);
        step(); step();

        // R2, R7: crossed reads, each processor to a different module
        for (int p = 0; p < NP; p++)
            issue(p, 1'b0, NM - 1 - p, 5, '0, 1, "R7");
        #1;
        chk(m_we == '0, "R8", "reads do not write", 64'(m_we), 0);
        step(); step();

        // R3, R5: all four contend for module 2
        issue(0, 1'b0, 2, 5, '0, 1, "R3");
        issue(1, 1'b1, 2, 9, 16'h1234, 2, "R5");
        issue(2, 1'b0, 2, 5, '0, 3, "R5");
        issue(3, 1'b0, 2, 5, '0, 4, "R5");
        #1;
        chk(m_we[2] == 1'b0, "R3", "proc 0 read wins", 64'(m_we[2]), 0);
        repeat (6) step();

        // R3: a late high-priority request overtakes a waiting one
        issue(2, 1'b0, 1, 5, '0, 1, "R3");
        issue(3, 1'b0, 1, 5, '0, 3, "R3");
        step();
        issue(0, 1'b0, 1, 5, '0, 1, "R3");
        repeat (5) step();

        // R9: request re-presented in its own ack cycle slips one cycle
        issue(1, 1'b0, 0, 5, '0, 1, "R9");
        step();
        issue(1, 1'b0, 3, 5, '0, 2, "R9");
        repeat (4) step();

        // R2, R6: rotating write/read traffic across modules
        for (int r = 0; r < 6; r++) begin
            for (int p = 0; p < NP; p++)
                issue(p, 1'b1, (p + r) % NM, 20 + r, DW'(16'h5000 + (p << 8) + r), 1, "R2");
            step(); step();
        end
        for (int r = 0; r < 6; r++) begin
            for (int p = 0; p < NP; p++)
                issue(p, 1'b0, (p + r + 1) % NM, 20 + r, '0, 1, "R2");
            step(); step();
        end
        issue(1, 1'b0, 2, 9, '0, 1, "R8");
        repeat (6) step();

        chk(sb.size() == 0, "R5", "outstanding expectations", 64'(sb.size()), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule